// File: doc/BRIEF.md
# FSK Tag Frame Demodulator

This block recovers frames from the answer of a low-frequency tag that sends bits by switching between two carrier frequencies. Its input is a one-bit stream of zero-crossing samples, one sample per clock, at a fixed sample rate. The block counts carrier cycles on every low-to-high transition of that stream. At the end of each group of cycles it measures how many samples the group took.

The measured span is sorted into one of three classes: a logic 1 (the lower carrier frequency), a logic 0 (the higher one), or noise. Bits arrive least significant first and are pushed into the top of a 128-bit register that shifts right. Noise discards everything collected so far.

After every bit, the register is tested for a frame signature: a fixed preamble and a closing byte equal to the opening byte. When a frame is accepted, the block presents the 64-bit data word, the 16-bit check field, a rewritable flag and an ident-match flag with a one-cycle strobe. It then starts hunting for the next frame from an empty register.

Top module: `fsk_frame_demod`

## Requirements
- R1: A carrier cycle is counted on each clock where `sample_in` is 1 and was 0 in the previous clock. The span of a group is the number of clocks between the clock that counts its 16th cycle and the clock that counted the 16th cycle of the group before it (CYC_PER_BIT = 16).
- R2: The nominal spans are N1 = floor(SAMPLE_HZ*16/F_ONE_HZ) and N0 = floor(SAMPLE_HZ*16/F_ZERO_HZ), with tolerance T = (N1-N0+1)/2 (integer division). The defaults give N1 = 259, N0 = 238 and T = 11. A span strictly between N1-T and N1+T is a logic 1.
- R3: A span strictly between N0-T and N0+T is a logic 0. With the defaults, 249 is a 1 and 248 is a 0.
- R4: A span in neither window is noise and clears the whole 128-bit register. This includes a span at exactly N0+T = N1-T when T makes the windows leave a gap.
- R5: Each new bit enters at register bit 127 while the register shifts right by one. The first bit of a frame therefore ends at bit 0. Data is register bits [87:24] and the check field is bits [103:88].
- R6: A candidate frame needs register bits [22:0] equal to 0x7E0000. In arrival order, that is 17 zeros followed by 6 ones.
- R7: A candidate is accepted only when register bits [111:104] equal bits [23:16]. Otherwise no strobe is given.
- R8: `frame_rewritable` is register bit 111 of the accepted frame.
- R9: `frame_ident_ok` is 1 only when the frame is rewritable and register bits [126:112] equal data bits [14:0].
- R10: `frame_valid` is high for exactly one clock, the clock after the edge that samples the completing cycle. The frame outputs change only with that strobe and hold until the next one.
- R11: Accepting a frame clears the register, so the next frame needs all 128 of its bits again.
- R12: The synchronous reset `rst` clears the cycle counter, the span counter, the register and all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one sample per cycle |
| rst | input | 1 | Synchronous reset, active high |
| sample_in | input | 1 | Zero-crossing sample of the tag signal |
| frame_valid | output | 1 | One-cycle strobe: a frame was accepted |
| frame_data | output | 64 | Data word of the last accepted frame |
| frame_check | output | 16 | Check field of the last accepted frame |
| frame_rewritable | output | 1 | Rewritable flag of the last accepted frame |
| frame_ident_ok | output | 1 | Ident field matches the low data bits (rewritable frames only) |

## Verification
Two functions can fall in the same cycle: the shift of the bit that completes a signature, and the acceptance that clears the register. The bench provokes this with a frame whose data field repeats the signature 24 bits higher. It then sends 24 further bits that would form a second valid frame if the old contents survived the acceptance. The bench judges the result by counting strobes, which must not grow during those extra bits. It also checks that the fields captured at the single strobe match the first frame.

// File: rtl/fskd_pkg.sv
package fskd_pkg;

   typedef enum logic [1:0] {
      BIT_ZERO  = 2'd0,
      BIT_ONE   = 2'd1,
      BIT_NOISE = 2'd2
   } bit_class_e;

   localparam int FRAME_W  = 128;
   localparam int DATA_W   = 64;
   localparam int CHK_W    = 16;
   localparam int ID_W     = 15;
   localparam int SIG_W    = 23;
   localparam int HEAD_LSB = 16;
   localparam int DATA_LSB = 24;
   localparam int CHK_LSB  = 88;
   localparam int TAIL_LSB = 104;
   localparam int RW_POS   = 111;
   localparam int ID_LSB   = 112;
   localparam int MARK_W   = 8;

   localparam logic [SIG_W-1:0] SIG_VALUE = 23'h7E0000;

endpackage

// File: rtl/fskd_cycle_timer.sv
module fskd_cycle_timer #(
   parameter int CYC_PER_BIT = 16,
   parameter int SPAN_W      = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sample_in,
   output logic              meas_stb,
   output logic [SPAN_W-1:0] span
);
   localparam int CYC_W = (CYC_PER_BIT > 1) ? $clog2(CYC_PER_BIT) : 1;
   localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CYC_PER_BIT - 1);

   logic              prev_q;
   logic [CYC_W-1:0]  cyc_q;
   logic [SPAN_W-1:0] span_q;
   logic              rise;
   logic              group_end;

   assign rise      = sample_in & ~prev_q;
   assign group_end = rise && (cyc_q == CYC_LAST);

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_q <= 1'b1;
         cyc_q  <= '0;
      end else begin
         prev_q <= sample_in;
         if (rise) begin
            if (group_end) cyc_q <= '0;
            else           cyc_q <= cyc_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         span_q <= '0;
      end else if (group_end) begin
         span_q <= SPAN_W'(1);
      end else if (span_q != '1) begin
         span_q <= span_q + 1'b1;
      end
   end

   assign meas_stb = group_end;
   assign span     = span_q;

endmodule

// File: rtl/fskd_classifier.sv
module fskd_classifier
   import fskd_pkg::*;
#(
   parameter int SPAN_W = 10,
   parameter int N_ONE  = 259,
   parameter int N_ZERO = 238,
   parameter int TOL    = 11
) (
   input  logic [SPAN_W-1:0] span,
   output bit_class_e        cls
);
   localparam int ONE_LO  = N_ONE - TOL;
   localparam int ONE_HI  = N_ONE + TOL;
   localparam int ZERO_LO = N_ZERO - TOL;
   localparam int ZERO_HI = N_ZERO + TOL;

   logic [31:0] span_i;
   logic        in_one;
   logic        in_zero;

   assign span_i  = 32'(span);
   assign in_one  = (span_i > 32'(ONE_LO))  && (span_i < 32'(ONE_HI));
   assign in_zero = (span_i > 32'(ZERO_LO)) && (span_i < 32'(ZERO_HI));

   always_comb begin
      if (in_one)       cls = BIT_ONE;
      else if (in_zero) cls = BIT_ZERO;
      else              cls = BIT_NOISE;
   end

endmodule

// File: rtl/fskd_frame_reg.sv
module fskd_frame_reg
   import fskd_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  logic              meas_stb,
   input  bit_class_e        cls,
   output logic              frame_valid,
   output logic [DATA_W-1:0] frame_data,
   output logic [CHK_W-1:0]  frame_check,
   output logic              frame_rewritable,
   output logic              frame_ident_ok
);
   logic [FRAME_W-1:0] sr_q;
   logic [FRAME_W-1:0] sr_next;
   logic [ID_W-1:0]    id_eq;
   logic               sig_hit;
   logic               mark_hit;
   logic               accept;

   assign sr_next = {cls == BIT_ONE, sr_q[FRAME_W-1:1]};

   genvar gi;
   generate
      for (gi = 0; gi < ID_W; gi++) begin : g_id_cmp
         assign id_eq[gi] = ~(sr_next[ID_LSB+gi] ^ sr_next[DATA_LSB+gi]);
      end
   endgenerate

   assign sig_hit  = (sr_next[SIG_W-1:0] == SIG_VALUE);
   assign mark_hit = (sr_next[HEAD_LSB +: MARK_W] == sr_next[TAIL_LSB +: MARK_W]);
   assign accept   = meas_stb && (cls != BIT_NOISE) && sig_hit && mark_hit;

   always_ff @(posedge clk) begin
      if (rst) begin
         sr_q <= '0;
      end else if (meas_stb) begin
         if (cls == BIT_NOISE || accept) sr_q <= '0;
         else                            sr_q <= sr_next;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         frame_valid      <= 1'b0;
         frame_data       <= '0;
         frame_check      <= '0;
         frame_rewritable <= 1'b0;
         frame_ident_ok   <= 1'b0;
      end else begin
         frame_valid <= accept;
         if (accept) begin
            frame_data       <= sr_next[DATA_LSB +: DATA_W];
            frame_check      <= sr_next[CHK_LSB +: CHK_W];
            frame_rewritable <= sr_next[RW_POS];
            frame_ident_ok   <= sr_next[RW_POS] && (&id_eq);
         end
      end
   end

endmodule

// File: rtl/fsk_frame_demod.sv
module fsk_frame_demod
   import fskd_pkg::*;
#(
   parameter int SAMPLE_HZ   = 2000000,
   parameter int F_ONE_HZ    = 123200,
   parameter int F_ZERO_HZ   = 134200,
   parameter int CYC_PER_BIT = 16
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        sample_in,
   output logic        frame_valid,
   output logic [63:0] frame_data,
   output logic [15:0] frame_check,
   output logic        frame_rewritable,
   output logic        frame_ident_ok
);
   localparam longint SCALED = longint'(SAMPLE_HZ) * longint'(CYC_PER_BIT);
   localparam int N_ONE    = int'(SCALED / longint'(F_ONE_HZ));
   localparam int N_ZERO   = int'(SCALED / longint'(F_ZERO_HZ));
   localparam int TOL      = (N_ONE - N_ZERO + 1) / 2;
   localparam int SPAN_MAX = N_ONE + TOL;
   localparam int SPAN_W   = $clog2(SPAN_MAX + 1) + 1;

   generate
      if (F_ONE_HZ >= F_ZERO_HZ) begin : g_bad_order
         $error("one-frequency must be below zero-frequency");
      end
      if (CYC_PER_BIT < 2) begin : g_bad_cycles
         $error("at least two cycles per bit are needed");
      end
      if (N_ZERO - TOL < 1) begin : g_bad_rate
         $error("sample rate too low for the chosen frequencies");
      end
   endgenerate

   logic              meas_stb;
   logic [SPAN_W-1:0] span;
   bit_class_e        cls;

   fskd_cycle_timer #(
      .CYC_PER_BIT (CYC_PER_BIT),
      .SPAN_W      (SPAN_W)
   ) u_timer (
      .clk       (clk),
      .rst       (rst),
      .sample_in (sample_in),
      .meas_stb  (meas_stb),
      .span      (span)
   );

   fskd_classifier #(
      .SPAN_W (SPAN_W),
      .N_ONE  (N_ONE),
      .N_ZERO (N_ZERO),
      .TOL    (TOL)
   ) u_class (
      .span (span),
      .cls  (cls)
   );

   fskd_frame_reg u_frame (
      .clk              (clk),
      .rst              (rst),
      .meas_stb         (meas_stb),
      .cls              (cls),
      .frame_valid      (frame_valid),
      .frame_data       (frame_data),
      .frame_check      (frame_check),
      .frame_rewritable (frame_rewritable),
      .frame_ident_ok   (frame_ident_ok)
   );

endmodule

// File: rtl/fskd_checker.sv
module fskd_checker (
   input logic        clk,
   input logic        rst,
   input logic        sample_in,
   input logic        frame_valid,
   input logic [63:0] frame_data,
   input logic [15:0] frame_check,
   input logic        frame_rewritable,
   input logic        frame_ident_ok
);

   // R10: the strobe lasts a single clock
   p_single_pulse_r10: assert property (@(posedge clk) disable iff (rst)
      frame_valid |=> !frame_valid);

   // R10: fields hold between strobes
   p_fields_hold_r10: assert property (@(posedge clk) disable iff (rst)
      !frame_valid |-> ($stable(frame_data) && $stable(frame_check)
                        && $stable(frame_rewritable) && $stable(frame_ident_ok)));

   // R1: acceptance follows a low-to-high transition of the input
   p_after_rise_r1: assert property (@(posedge clk) disable iff (rst)
      frame_valid |-> ($past(sample_in) && !$past(sample_in, 2)));

   // R9: an ident match is reported only for rewritable frames
   p_ident_rw_r9: assert property (@(posedge clk) disable iff (rst)
      frame_valid |-> (!frame_ident_ok || frame_rewritable));

   // R12: no strobe right after reset
   p_reset_quiet_r12: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!frame_valid && frame_data == 64'd0));

endmodule

bind fsk_frame_demod fskd_checker u_fskd_checker (
   .clk              (clk),
   .rst              (rst),
   .sample_in        (sample_in),
   .frame_valid      (frame_valid),
   .frame_data       (frame_data),
   .frame_check      (frame_check),
   .frame_rewritable (frame_rewritable),
   .frame_ident_ok   (frame_ident_ok)
);

// File: tb/fsk_frame_demod_tb_top.sv
module fsk_frame_demod_tb_top;

   localparam int SR  = 1000000;
   localparam int F1  = 123200;
   localparam int F0  = 134200;
   localparam int CPB = 16;
   localparam int N1  = (SR * CPB) / F1;
   localparam int N0  = (SR * CPB) / F0;
   localparam int TOL = (N1 - N0 + 1) / 2;
   localparam int ONE_MIN  = N1 - TOL + 1;
   localparam int ONE_MAX  = N1 + TOL - 1;
   localparam int ZERO_MIN = N0 - TOL + 1;
   localparam int ZERO_MAX = N0 + TOL - 1;
   localparam int GAP_SPAN = N0 + TOL;
   localparam int HIGH_OUT = N1 + TOL;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        sample_in = 1'b0;
   logic        frame_valid;
   logic [63:0] frame_data;
   logic [15:0] frame_check;
   logic        frame_rewritable;
   logic        frame_ident_ok;

   int checks = 0;
   int errors = 0;
   int pulses = 0;
   int doubles = 0;
   bit reported = 1'b0;
   logic        last_fv = 1'b0;
   logic [63:0] cap_data = '0;
   logic [15:0] cap_chk = '0;
   logic        cap_rw = 1'b0;
   logic        cap_id = 1'b0;

   always #5 clk = ~clk;

   fsk_frame_demod #(
      .SAMPLE_HZ   (SR),
      .F_ONE_HZ    (F1),
      .F_ZERO_HZ   (F0),
      .CYC_PER_BIT (CPB)
   ) dut_i (
      .clk              (clk),
      .rst              (rst),
      .sample_in        (sample_in),
      .frame_valid      (frame_valid),
      .frame_data       (frame_data),
      .frame_check      (frame_check),
      .frame_rewritable (frame_rewritable),
      .frame_ident_ok   (frame_ident_ok)
   );

   always @(negedge clk) begin
      if (!rst && frame_valid) begin
         pulses   <= pulses + 1;
         cap_data <= frame_data;
         cap_chk  <= frame_check;
         cap_rw   <= frame_rewritable;
         cap_id   <= frame_ident_ok;
         if (last_fv) doubles <= doubles + 1;
      end
      last_fv <= frame_valid;
   end

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1'b1;
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      end
   endtask

   // one group of CPB cycles whose 16th-rise spacing equals span
   task automatic send_group(input int span);
      for (int c = 0; c < CPB; c++) begin
         int len;
         len = span / CPB + ((c < span % CPB) ? 1 : 0);
         for (int s = 0; s < len; s++) begin
            @(negedge clk);
            sample_in = (s >= len - 4);
         end
      end
   endtask

   task automatic send_bits(input logic [127:0] v, input int first, input int last,
                            input int sp1, input int sp0);
      for (int i = first; i <= last; i++) send_group(v[i] ? sp1 : sp0);
   endtask

   function automatic logic [127:0] make_frame(input logic [63:0] d, input logic [15:0] c,
                                               input logic rw, input logic [14:0] id,
                                               input logic flip);
      logic [127:0] v;
      v = '0;
      v[22:17]   = 6'h3F;
      v[23]      = rw;
      v[87:24]   = d;
      v[103:88]  = c;
      v[111:104] = v[23:16];
      v[104]     = v[104] ^ flip;
      v[126:112] = id;
      return v;
   endfunction

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset_state();
      check("R12 valid after reset", 64'(frame_valid), 64'd0);
      check("R12 data after reset", frame_data, 64'd0);
      check("R12 check after reset", 64'(frame_check), 64'd0);
      check("R12 rewritable after reset", 64'(frame_rewritable), 64'd0);
      check("R12 ident after reset", 64'(frame_ident_ok), 64'd0);
   endtask

   // R2 R3 R5 R6 R7 R8 R9: rewritable frame, edge-of-window spans (low side)
   task automatic t_rw_frame_low_edges();
      logic [63:0]  d;
      logic [127:0] v;
      d = 64'hC3A5_1E96_0F5A_2B4D;
      v = make_frame(d, 16'h9D31, 1'b1, d[14:0], 1'b0);
      send_bits(v, 0, 127, ONE_MIN, ZERO_MAX);
      settle();
      check("R6 R7 strobe count", 64'(pulses), 64'd1);
      check("R2 R3 R5 data", cap_data, d);
      check("R5 check field", 64'(cap_chk), 64'h9D31);
      check("R8 rewritable", 64'(cap_rw), 64'd1);
      check("R9 ident match", 64'(cap_id), 64'd1);
   endtask

   // R2 R3 R8 R11: read-only frame with far-edge spans, then a tail that would re-form a frame
   task automatic t_ro_frame_and_clear();
      logic [63:0]  d;
      logic [127:0] v;
      logic [127:0] tail;
      d = 64'h5A5A_A5C3_007E_0000;
      v = make_frame(d, 16'h3C96, 1'b0, 15'h4321, 1'b0);
      send_bits(v, 0, 127, ONE_MAX, ZERO_MIN);
      settle();
      check("R2 R3 strobe count", 64'(pulses), 64'd2);
      check("R2 R3 data", cap_data, d);
      check("R5 check field", 64'(cap_chk), 64'h3C96);
      check("R8 read-only", 64'(cap_rw), 64'd0);
      check("R9 ident on read-only", 64'(cap_id), 64'd0);
      tail = '0;
      tail[7:0] = 8'h7E;
      send_bits(tail, 0, 23, N1, N0);
      settle();
      check("R11 no second strobe after clear", 64'(pulses), 64'd2);
   endtask

   task automatic t_mid_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      check("R12 data cleared", frame_data, 64'd0);
      check("R12 check cleared", 64'(frame_check), 64'd0);
      check("R12 flags cleared", 64'({frame_rewritable, frame_ident_ok}), 64'd0);
      rst = 1'b0;
      send_group(N1);
   endtask

   // R9: rewritable frame whose ident field differs from the data
   task automatic t_ident_mismatch();
      logic [127:0] v;
      v = make_frame(64'h0F1E_2D3C_4B5A_6978, 16'h5AC3, 1'b1, 15'h1234, 1'b0);
      send_bits(v, 0, 127, N1, N0);
      settle();
      check("R1 strobe count", 64'(pulses), 64'd3);
      check("R9 data", cap_data, 64'h0F1E_2D3C_4B5A_6978);
      check("R8 rewritable", 64'(cap_rw), 64'd1);
      check("R9 ident mismatch", 64'(cap_id), 64'd0);
   endtask

   // R7: closing byte differs from opening byte
   task automatic t_mark_mismatch();
      logic [63:0]  d;
      logic [127:0] v;
      d = 64'hC3A5_1E96_0F5A_2B4D;
      v = make_frame(d, 16'h9D31, 1'b1, d[14:0], 1'b1);
      send_bits(v, 0, 127, N1, N0);
      settle();
      check("R7 no strobe on byte mismatch", 64'(pulses), 64'd3);
   endtask

   // R4: gap span between windows clears bits already collected
   task automatic t_noise_clears();
      logic [127:0] v;
      v = make_frame(64'h0F1E_2D3C_4B5A_6978, 16'h5AC3, 1'b1, 15'h1234, 1'b0);
      send_bits(v, 0, 99, N1, N0);
      send_group(GAP_SPAN);
      send_bits(v, 100, 127, N1, N0);
      settle();
      check("R4 gap span clears register", 64'(pulses), 64'd3);
   endtask

   // R4: a span just above the one-window is not a bit
   task automatic t_noise_not_bit();
      logic [63:0]  d;
      logic [127:0] v;
      d = 64'hC3A5_1E96_0F5A_2B4D;
      v = make_frame(d, 16'h9D31, 1'b1, d[14:0], 1'b0);
      send_bits(v, 0, 126, N1, N0);
      send_group(HIGH_OUT);
      settle();
      check("R4 out-of-window span is noise", 64'(pulses), 64'd3);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      t_reset_state();
      rst = 1'b0;
      send_group(N1);
      t_rw_frame_low_edges();
      t_ro_frame_and_clear();
      t_mid_reset();
      t_ident_mismatch();
      t_mark_mismatch();
      t_noise_clears();
      t_noise_not_bit();
      check("R10 strobe width", 64'(doubles), 64'd0);
      report();
      $finish;
   end

   initial begin
      repeat (180000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
   end

endmodule